// File: doc/BRIEF.md
# Serial Mode-Register Loader

This block receives configuration words over three wires: a data line, a shift strobe and a latch strobe. Each rising edge of the shift strobe moves one data bit into an assembly register. A rising edge of the latch strobe then commits the whole word in one step to one of four mode registers. The two leading bits of the word pick the target register, and the rest of the word becomes that register's payload. The mode registers feed the gain code, the input format and the system options used by neighbouring blocks. This block routes words and does not decode the fields inside them.

All three strobes are asynchronous to the system clock. They are synchronized through a chain of flops, and their edges are detected in the clock domain. A latch that arrives after the wrong number of shift edges is dropped and raises an error flag. Each successful write produces a one-cycle update pulse for the register it touched, so that downstream logic can restart a ramp or resynchronize.

Top module: `smr_serial_cfg`

## Requirements
- R1: A word is WORD_W (24) bits long. Only rising edges of the shift strobe accept a bit, and the bit accepted is the synchronized data level. The first bit shifted is word bit 1.
- R2: Word bits 1 and 2 select the target register, with bit 1 as the index MSB: 00 is register 0, 01 is register 1, 10 is register 2 and 11 is register 3.
- R3: Word bits 3 to 24 become the 22-bit payload of the selected register. Bit 3 is payload bit 21 and bit 24 is payload bit 0. Register g occupies mode_regs_o[g*22 +: 22].
- R4: A latch rising edge after exactly 24 shift edges writes the whole payload at once. No register changes while bits are still being shifted.
- R5: A latch rising edge after fewer or more than 24 shift edges (including zero) changes no register, produces no update pulse and sets frame_err_o.
- R6: frame_err_o stays set until the next valid latch clears it.
- R7: Reset clears all four registers, frame_err_o and the update pulses, and discards any partly shifted word.
- R8: Each valid write raises the selected register's bit of mode_upd_o for exactly one clock. No other bit is high in that cycle.
- R9: The bit count restarts after every latch, whether the latch was valid or not, so the next word is received independently of the one before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_data_i | input | 1 | Serial data, asynchronous |
| cfg_shift_i | input | 1 | Shift strobe; a rising edge accepts one bit |
| cfg_latch_i | input | 1 | Latch strobe; a rising edge commits the word |
| mode_regs_o | output | 88 | Four 22-bit mode registers, register 0 in the low bits |
| mode_upd_o | output | 4 | One-cycle write pulse per register |
| frame_err_o | output | 1 | Set by a latch after the wrong number of shift edges |

## Verification
The bench builds the block with its default values: a 24-bit word, a 2-bit select and a 2-stage synchronizer. With these values all four select codes, a 22-bit payload of all ones, alternating patterns and a single set LSB can all be reached. The word-length boundary is exercised on both sides, with frames of 23 and 25 bits, and also with a latch that has no shift edge before it. Directed cases check the registers halfway through a frame and apply a reset in the middle of a partly shifted word.

// File: rtl/smr_pkg.sv
package smr_pkg;

    // Progress of the word being assembled
    typedef enum logic [1:0] {
        FR_IDLE     = 2'd0,  // no bit received since last latch/reset
        FR_PARTIAL  = 2'd1,  // fewer than a full word received
        FR_FULL     = 2'd2,  // exactly one full word received
        FR_OVERRUN  = 2'd3   // more bits than a word received
    } frame_st_e;

endpackage

// File: rtl/smr_sync_chain.sv
module smr_sync_chain #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];

    initial begin
        assert_stages_R1: assert (STAGES >= 2)
            else $error("synchronizer needs at least two stages");
    end
endmodule

// File: rtl/smr_word_assembler.sv
module smr_word_assembler
    import smr_pkg::*;
#(
    parameter int unsigned WORD_W = 24,
    parameter int unsigned SEL_W  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      data_s_i,
    input  logic                      shift_s_i,
    input  logic                      latch_s_i,
    output logic                      wr_o,
    output logic [SEL_W-1:0]          sel_o,
    output logic [WORD_W-SEL_W-1:0]   pay_o,
    output logic                      err_o
);
    localparam int unsigned PAY_W = WORD_W - SEL_W;
    localparam int unsigned CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WORD_W - 1);

    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
        frame_st_e         st;
        logic              shift_prev;
        logic              latch_prev;
        logic              wr;
        logic [SEL_W-1:0]  sel;
        logic [PAY_W-1:0]  pay;
        logic              err;
    } asm_state_t;

    asm_state_t state_d, state_q;
    logic shift_rise, latch_rise;

    always_comb begin
        shift_rise = shift_s_i & ~state_q.shift_prev;
        latch_rise = latch_s_i & ~state_q.latch_prev;

        state_d            = state_q;
        state_d.shift_prev = shift_s_i;
        state_d.latch_prev = latch_s_i;
        state_d.wr         = 1'b0;

        if (latch_rise) begin
            if (state_q.st == FR_FULL) begin
                state_d.wr  = 1'b1;
                state_d.sel = state_q.sh[WORD_W-1 -: SEL_W];
                state_d.pay = state_q.sh[PAY_W-1:0];
                state_d.err = 1'b0;
            end else begin
                state_d.err = 1'b1;
            end
            state_d.st  = FR_IDLE;
            state_d.cnt = '0;
        end else if (shift_rise) begin
            state_d.sh = {state_q.sh[WORD_W-2:0], data_s_i};
            unique case (state_q.st)
                FR_FULL, FR_OVERRUN: state_d.st = FR_OVERRUN;
                default: begin
                    state_d.cnt = state_q.cnt + 1'b1;
                    state_d.st  = (state_q.cnt == LAST_CNT) ? FR_FULL : FR_PARTIAL;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign wr_o  = state_q.wr;
    assign sel_o = state_q.sel;
    assign pay_o = state_q.pay;
    assign err_o = state_q.err;

    // R1: bit count never exceeds one word
    assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.cnt <= CNT_W'(WORD_W));

    // R5: wrong-length latch raises error and writes nothing
    assert_bad_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_rise && state_q.st != FR_FULL) |=> (state_q.err && !state_q.wr));

    // R4 and R6: full-length latch writes and clears the error
    assert_good_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_rise && state_q.st == FR_FULL) |=> (state_q.wr && !state_q.err));

    // R9: every latch restarts the frame
    assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        latch_rise |=> (state_q.st == FR_IDLE));
endmodule

// File: rtl/smr_reg_bank.sv
module smr_reg_bank #(
    parameter int unsigned SEL_W = 2,
    parameter int unsigned PAY_W = 22
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_i,
    input  logic [SEL_W-1:0]                  sel_i,
    input  logic [PAY_W-1:0]                  pay_i,
    output logic [(PAY_W*(2**SEL_W))-1:0]     regs_o,
    output logic [(2**SEL_W)-1:0]             upd_o
);
    localparam int unsigned NUM_REGS = 2 ** SEL_W;

    typedef struct packed {
        logic [NUM_REGS-1:0][PAY_W-1:0] regs;
        logic [NUM_REGS-1:0]            upd;
    } bank_state_t;

    bank_state_t state_d, state_q;

    always_comb begin
        state_d     = state_q;
        state_d.upd = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (wr_i && (sel_i == SEL_W'(r))) begin
                state_d.regs[r] = pay_i;
                state_d.upd[r]  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_out
        assign regs_o[g*PAY_W +: PAY_W] = state_q.regs[g];
    end
    assign upd_o = state_q.upd;

    // R8: at most one update pulse at a time
    assert_upd_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(state_q.upd));

    // R2: the write lands on the selected register's pulse
    assert_route_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (state_q.upd == (NUM_REGS'(1) << $past(sel_i))));

    // R3: selected register takes the payload
    assert_payload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (state_q.regs[$past(sel_i)] == $past(pay_i)));

    // R4 and R5: without a write the registers hold
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> ($stable(state_q.regs) && (state_q.upd == '0)));
endmodule

// File: rtl/smr_serial_cfg.sv
module smr_serial_cfg #(
    parameter int unsigned WORD_W      = 24,
    parameter int unsigned SEL_W       = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic                                         cfg_data_i,
    input  logic                                         cfg_shift_i,
    input  logic                                         cfg_latch_i,
    output logic [((WORD_W-SEL_W)*(2**SEL_W))-1:0]       mode_regs_o,
    output logic [(2**SEL_W)-1:0]                        mode_upd_o,
    output logic                                         frame_err_o
);
    localparam int unsigned PAY_W   = WORD_W - SEL_W;
    localparam int unsigned N_LINES = 3;

    logic [N_LINES-1:0] line_async, line_sync;
    logic               wr;
    logic [SEL_W-1:0]   sel;
    logic [PAY_W-1:0]   pay;

    assign line_async = {cfg_latch_i, cfg_shift_i, cfg_data_i};

    // Data shares the strobes' depth so a bit lines up with its shift edge
    for (genvar g = 0; g < N_LINES; g++) begin : g_sync
        smr_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (line_async[g]),
            .sync_o  (line_sync[g])
        );
    end

    smr_word_assembler #(.WORD_W(WORD_W), .SEL_W(SEL_W)) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_s_i  (line_sync[0]),
        .shift_s_i (line_sync[1]),
        .latch_s_i (line_sync[2]),
        .wr_o      (wr),
        .sel_o     (sel),
        .pay_o     (pay),
        .err_o     (frame_err_o)
    );

    smr_reg_bank #(.SEL_W(SEL_W), .PAY_W(PAY_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (wr),
        .sel_i  (sel),
        .pay_i  (pay),
        .regs_o (mode_regs_o),
        .upd_o  (mode_upd_o)
    );
endmodule

// File: tb/test_smr_serial_cfg.sv
module test_smr_serial_cfg;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 9;

    // word bits listed from word bit 1 (index 23) to bit 24 (index 0)
    localparam logic [23:0] VEC_WORD [NV] = '{
        24'h3FFFFF, 24'h555555, 24'hAAAAAA, 24'hC00001, 24'h123456,
        24'h800000, 24'hFFFFFF, 24'h000000, 24'h7ABCDE };
    localparam int VEC_LEN [NV] = '{24, 24, 24, 24, 23, 24, 25, 0, 24};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_data = 1'b0, cfg_shift = 1'b0, cfg_latch = 1'b0;
    logic [87:0] mode_regs;
    logic [3:0]  mode_upd;
    logic        frame_err;

    int checks = 0, errors = 0;
    int upd_cnt [4] = '{0, 0, 0, 0};
    int multi_cnt = 0;
    logic [21:0] exp_reg [4] = '{22'd0, 22'd0, 22'd0, 22'd0};
    logic exp_err = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smr_serial_cfg i_smr_serial_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_data_i  (cfg_data),
        .cfg_shift_i (cfg_shift),
        .cfg_latch_i (cfg_latch),
        .mode_regs_o (mode_regs),
        .mode_upd_o  (mode_upd),
        .frame_err_o (frame_err)
    );

    // update pulse monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < 4; i++) if (mode_upd[i]) upd_cnt[i]++;
            if ($countones(mode_upd) > 1) multi_cnt++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic shift_bit(input logic b);
        @(negedge clk) cfg_data = b;
        repeat (3) @(negedge clk);
        cfg_shift = 1'b1;
        repeat (3) @(negedge clk);
        cfg_shift = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_bits(input logic [23:0] w, input int first, input int n);
        for (int i = first; i < first + n; i++)
            shift_bit((i < 24) ? w[23-i] : 1'b0);
    endtask

    task automatic latch_word();
        @(negedge clk) cfg_latch = 1'b1;
        repeat (3) @(negedge clk);
        cfg_latch = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic check_all(input string req, input int upd_before [4], input logic [3:0] exp_upd);
        for (int r = 0; r < 4; r++) begin
            chk({req, " reg"}, 32'(mode_regs[r*22 +: 22]), 32'(exp_reg[r]));
            chk({req, " upd R8"}, 32'(upd_cnt[r] - upd_before[r]), 32'(exp_upd[r]));
        end
        chk({req, " err R5/R6"}, 32'(frame_err), 32'(exp_err));
        chk("R8 single pulse", 32'(multi_cnt), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int snap [4];
        repeat (4) @(negedge clk);
        // R7: reset state
        chk("R7 regs at reset", 32'(mode_regs != '0), 32'd0);
        chk("R7 upd at reset", 32'(mode_upd), 32'd0);
        chk("R7 err at reset", 32'(frame_err), 32'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // table: R1, R2, R3, R4, R5, R6, R9
        for (int v = 0; v < NV; v++) begin
            logic [3:0] eu;
            snap = upd_cnt;
            send_bits(VEC_WORD[v], 0, VEC_LEN[v]);
            latch_word();
            eu = '0;
            if (VEC_LEN[v] == 24) begin
                exp_reg[VEC_WORD[v][23:22]] = VEC_WORD[v][21:0];
                eu[VEC_WORD[v][23:22]] = 1'b1;
                exp_err = 1'b0;
            end else begin
                exp_err = 1'b1;
            end
            check_all($sformatf("R1 R2 R3 R9 vec%0d", v), snap, eu);
        end

        // R4: nothing changes halfway through a frame
        snap = upd_cnt;
        send_bits(24'h412345, 0, 12);
        check_all("R4 mid-frame", snap, 4'b0000);
        send_bits(24'h412345, 12, 12);
        latch_word();
        exp_reg[1] = 22'h012345;
        exp_err = 1'b0;
        check_all("R4 completed frame", snap, 4'b0010);

        // R7: reset in the middle of a partial word
        send_bits(24'hFFFFFF, 0, 10);
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 regs after reset", 32'(mode_regs != '0), 32'd0);
        chk("R7 err after reset", 32'(frame_err), 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        for (int r = 0; r < 4; r++) exp_reg[r] = '0;
        snap = upd_cnt;
        send_bits(24'hC2AAAA, 0, 24);
        latch_word();
        exp_reg[3] = 22'h02AAAA;
        check_all("R7 frame after reset", snap, 4'b1000);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule